// File: doc/BRIEF.md
# Filter-Mode Phase Slope Limiter

This block sits in the digital loop of a clock-synchronizing PLL, between the phase detector and the loop filter. Each signed phase error sample from the detector has its magnitude clamped to a bound. The bound depends on the selected loop bandwidth. Because the loop filter only ever sees a limited error, the output clock phase can move only at a bounded rate. This matters mostly when a large phase step has to be removed, such as after a forced realignment of the output to the reference. Limiting makes lock take longer in exchange for a gentle phase slope.

A two-bit mode input selects the bandwidth, and with it the clamp bound:

| Mode code | Bandwidth | Bound parameter | Slope it corresponds to |
|---|---|---|---|
| 00 | 0.1 Hz | `LIM_SLOW` | 0.727 ppm |
| 01 | 1.5 Hz | `LIM_MID` | 31 ppm |
| 10 | 6 Hz | `LIM_FAST` | 31 ppm |
| 11 | 12 Hz | none (bypass) | unlimited |

Each bound is a parameter giving the largest error magnitude allowed per update period. The result is registered, so it appears one cycle after the sample. The block also gives:
- a flag that is high when the sample was altered;
- a saturating count of altered samples, which a synchronous reset clears.

Top module: `phase_slope_clamp`

## Requirements
- R1: While `srst` is high at a clock edge, that edge sets `out_vld`, `limiting`, `err_out` and `sat_cnt` to zero.
- R2: `out_vld` is high in the cycle after a cycle with `err_vld` high. It is low in the cycle after a cycle with `err_vld` low.
- R3: With `fmode` = 2'b00, the output is the input clamped to the range [-LIM_SLOW, +LIM_SLOW].
- R4: With `fmode` = 2'b01 the output is clamped to ±LIM_MID. With `fmode` = 2'b10 it is clamped to ±LIM_FAST.
- R5: With `fmode` = 2'b11 the output equals the input for every value, including the most negative and most positive codes, and `limiting` stays low.
- R6: An input whose magnitude is at most the active bound, including exactly +bound and -bound, passes through unchanged, and `limiting` stays low.
- R7: The most negative input code in a limited mode gives exactly -bound. It never wraps to a positive value.
- R8: `limiting` is high exactly in the output cycles where `err_out` differs from the sample it was produced from. It is never high while `out_vld` is low.
- R9: `sat_cnt` rises by one one cycle after each altered sample. It holds at all ones rather than wrapping.
- R10: When `err_vld` is low, `err_out` keeps its last value and `sat_cnt` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| err_vld | input | 1 | Phase error sample strobe |
| err_in | input | ERR_W | Signed phase error from the detector |
| fmode | input | 2 | Filter mode: 00 = 0.1 Hz, 01 = 1.5 Hz, 10 = 6 Hz, 11 = 12 Hz (no limit) |
| out_vld | output | 1 | Clamped sample strobe, one cycle after `err_vld` |
| err_out | output | ERR_W | Signed clamped error to the loop filter |
| limiting | output | 1 | The sample in `err_out` was clamped |
| sat_cnt | output | CNT_W | Saturating count of clamped samples |

## Verification
Every result of this block sits one register away from its stimulus. `err_out`, `out_vld`, `limiting` and the `sat_cnt` increment caused by a sample all change on the first clock edge after that sample is presented. The bench drives each sample on a falling edge and reads all four outputs one time unit after the next rising edge, so every check looks at the cycle in which that sample's result is due.

For the idle case, the bench lowers the strobe and reads the outputs one edge later. This shows that the strobe has dropped while the data and the count held. The counter saturation check runs on an instance with a narrow counter.

// File: rtl/phase_slope_clamp.sv
module phase_slope_clamp #(
  parameter int ERR_W    = 16,
  parameter int CNT_W    = 16,
  parameter int LIM_SLOW = 12,
  parameter int LIM_MID  = 512,
  parameter int LIM_FAST = 512
) (
  input  logic                    clk,
  input  logic                    srst,
  input  logic                    err_vld,
  input  logic signed [ERR_W-1:0] err_in,
  input  logic [1:0]              fmode,
  output logic                    out_vld,
  output logic signed [ERR_W-1:0] err_out,
  output logic                    limiting,
  output logic [CNT_W-1:0]        sat_cnt
);

  localparam logic signed [ERR_W-1:0] LS = LIM_SLOW[ERR_W-1:0];
  localparam logic signed [ERR_W-1:0] LM = LIM_MID[ERR_W-1:0];
  localparam logic signed [ERR_W-1:0] LF = LIM_FAST[ERR_W-1:0];
  localparam logic signed [ERR_W-1:0] MIN_CODE = {1'b1, {(ERR_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic signed [ERR_W-1:0] lim;
  logic signed [ERR_W-1:0] clamped;
  logic                    bypass;
  logic                    hit;

  assign bypass = (fmode == 2'b11);

  always_comb begin
    case (fmode)
      2'b00:   lim = LS;
      2'b01:   lim = LM;
      2'b10:   lim = LF;
      default: lim = '0;
    endcase
  end

  always_comb begin
    clamped = err_in;
    if (!bypass) begin
      if (err_in > lim)       clamped = lim;
      else if (err_in < -lim) clamped = -lim;
    end
  end

  assign hit = (clamped != err_in);

  always_ff @(posedge clk) begin
    if (srst) begin
      out_vld  <= 1'b0;
      limiting <= 1'b0;
      err_out  <= '0;
      sat_cnt  <= '0;
    end else begin
      out_vld  <= err_vld;
      limiting <= err_vld && hit;
      if (err_vld) err_out <= clamped;
      if (err_vld && hit && sat_cnt != CNT_MAX) sat_cnt <= sat_cnt + 1'b1;
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (srst)
    err_vld |=> out_vld);
  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (srst)
    !err_vld |=> !out_vld);
  // R3
  slow_bound_chk: assert property (@(posedge clk) disable iff (srst)
    (err_vld && fmode == 2'b00) |=> (err_out <= LS && err_out >= -LS));
  // R5
  bypass_chk: assert property (@(posedge clk) disable iff (srst)
    (err_vld && fmode == 2'b11) |=> (err_out == $past(err_in) && !limiting));
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (srst)
    (err_vld && fmode != 2'b11 && err_in == MIN_CODE) |=> err_out[ERR_W-1]);
  // R8
  flag_vld_chk: assert property (@(posedge clk) disable iff (srst)
    limiting |-> out_vld);
  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (srst)
    (limiting && $past(sat_cnt) != CNT_MAX) |-> sat_cnt == $past(sat_cnt) + 1'b1);
  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (srst)
    !err_vld |=> $stable(sat_cnt));

endmodule

// File: tb/phase_slope_clamp_tb_top.sv
module phase_slope_clamp_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int CW    = 4;
  localparam int L0    = 12;
  localparam int L1    = 512;
  localparam int L2    = 300;
  localparam int VMIN  = -32768;
  localparam int VMAX  = 32767;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic err_vld = 1'b0;
  logic signed [W-1:0] err_in = '0;
  logic [1:0] fmode = 2'b00;
  logic out_vld, limiting;
  logic signed [W-1:0] err_out;
  logic [CW-1:0] sat_cnt;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  phase_slope_clamp #(.ERR_W(W), .CNT_W(CW), .LIM_SLOW(L0), .LIM_MID(L1), .LIM_FAST(L2)) dut_i (
    .clk(clk), .srst(srst), .err_vld(err_vld), .err_in(err_in), .fmode(fmode),
    .out_vld(out_vld), .err_out(err_out), .limiting(limiting), .sat_cnt(sat_cnt));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model(input int v, input int m);
    int lim;
    if (m == 3) return v;
    lim = (m == 0) ? L0 : (m == 1) ? L1 : L2;
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  task automatic send(input string req, input int v, input int m);
    int e;
    @(negedge clk);
    err_vld = 1'b1;
    err_in  = W'(v);
    fmode   = 2'(m);
    @(posedge clk);
    #1;
    e = model(v, m);
    if (e != v && exp_cnt < 15) exp_cnt++;
    chk(req, "out_vld", int'(out_vld), 1);
    chk(req, "err_out", int'(err_out), e);
    chk(req, "limiting", int'(limiting), (e != v) ? 1 : 0);
    chk("R9", "sat_cnt", int'(sat_cnt), exp_cnt);
    @(negedge clk);
    err_vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    srst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "out_vld", int'(out_vld), 0);
    chk("R1", "limiting", int'(limiting), 0);
    chk("R1", "err_out", int'(err_out), 0);
    chk("R1", "sat_cnt", int'(sat_cnt), 0);
    exp_cnt = 0;
    @(negedge clk);
    srst = 1'b0;
  endtask

  task automatic t_slow();
    send("R3", 1000, 0);
    send("R3", -1000, 0);
    send("R6", 5, 0);
    send("R6", L0, 0);
    send("R6", -L0, 0);
    send("R3", L0 + 1, 0);
    send("R3", -L0 - 1, 0);
  endtask

  task automatic t_mid_fast();
    send("R4", 600, 1);
    send("R4", -600, 1);
    send("R6", L1, 1);
    send("R4", 600, 2);
    send("R4", -301, 2);
    send("R6", -L2, 2);
  endtask

  task automatic t_bypass();
    send("R5", VMIN, 3);
    send("R5", VMAX, 3);
    send("R5", -20000, 3);
  endtask

  task automatic t_extremes();
    send("R7", VMIN, 0);
    send("R7", VMIN, 1);
    send("R7", VMIN, 2);
    send("R8", VMAX, 2);
  endtask

  task automatic t_idle();
    int held;
    send("R8", 2000, 0);
    held = int'(err_out);
    @(negedge clk);
    err_in = W'(-5000);
    fmode  = 2'b00;
    @(posedge clk);
    #1;
    chk("R2", "out_vld idle", int'(out_vld), 0);
    chk("R8", "limiting idle", int'(limiting), 0);
    chk("R10", "err_out held", int'(err_out), held);
    chk("R10", "sat_cnt held", int'(sat_cnt), exp_cnt);
  endtask

  task automatic t_count_sat();
    for (int i = 0; i < 20; i++) send("R9", (i % 2) ? 4000 : -4000, 0);
    chk("R9", "sat_cnt saturated", int'(sat_cnt), 15);
    do_reset();
    send("R9", 100, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_slow();
    t_mid_fast();
    t_bypass();
    t_extremes();
    t_idle();
    t_count_sat();
    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule